// File: doc/BRIEF.md
# Opcode-Sequenced SPI Master

This block is a half-duplex SPI master whose transfers are described by a short program rather than issued byte by byte. The host places up to eight byte-wide opcodes in one 64-bit program register. Writing that register starts the sequencer, which walks the slots in order. Each opcode either selects a chip-select line, shifts bytes out of a 64-bit transmit register, shifts bytes into a 64-bit receive register, branches back with a loop count, or stops.

The sequencer stalls on the transmit register. A shift-out waits until the host has filled that register, and it frees the register as soon as it takes the data. Finished shift-ins raise a receive-full flag that the host clears by reading the data. Sticky flags record a write into a full transmit register, a read of an empty receive register, and a receive result that arrives while the previous one is still unread.

The serial clock runs in mode 0, and its rate comes from a divider field in the clock configuration register. A two-write pattern in that same register resets the sequencer.

Top module: `spi_seq_master`

## Requirements
- R1: After reset the status register reads 64'h0001_0000_0000_0000 (idle), all `cs_n` lines are high, and `sck` and `mosi` are low.
- R2: A write to the program register (address 4) while idle starts execution at slot 0, which is bits 63:56. Execution moves toward slot 7 (bits 7:0). It returns to idle on opcode 8'h00 or after slot 7, and every chip-select is released on entering idle. A high nibble of 0 with a nonzero low nibble, and any unlisted opcode, only advance.
- R3: Opcode 8'h1n with n in 1..NCS drives `cs_n[n-1]` low and the others high. n = 0 releases all lines. At most one line is ever low.
- R4: Opcode 8'h3n (n = 1..8) waits until the transmit register is full. It then takes the data, clears transmit-full, and sends the top n bytes, most significant bit first. 8'h30 is a no-op that does not wait.
- R5: Opcode 8'h4n (n = 1..8) receives 8n bits. The result goes to the low end of the receive register with the first bit received most significant and the upper bits zero, and receive-full is set. A host read of the receive register (address 3) clears receive-full. `mosi` stays low while receiving. 8'h40 is a no-op.
- R6: Opcode 8'hEn jumps to slot n[2:0] while the loop count is nonzero and decrements the count on each jump; otherwise it advances. The count is loaded from bits 39:32 of the counter configuration register (address 0) when the program starts.
- R7: With bit 10 of the counter configuration set at program start, the first shift-in waits for one transmit write and consumes it. Later shift-ins in that program do not wait. With bit 10 clear, a shift-in never waits for the transmit register.
- R8: SCK idles low. Every high phase, and every low phase within a byte, lasts div+1 system clocks, where div is bits 63:52 of the clock configuration register (address 1). MISO is sampled on the rising edge, and `mosi` changes only while `sck` is low.
- R9: A host write to the transmit register (address 2) while it is full sets transmit-overrun (bit 58) and leaves the data unchanged. A host read of an empty receive register sets receive-underrun (bit 61). A shift-in that completes while receive-full is set sets receive-overrun (bit 62) and replaces the data.
- R10: Any write to the status register (address 5) clears bits 58, 61 and 62.
- R11: A clock configuration write with bits 36 and 38 both set arms a reset. If the next clock configuration write has bits 37 and 39 both set, the sequencer goes idle, releases chip-selects and clears transmit-full and receive-full. The second write alone does nothing.
- R12: In the status register, bit 63 is receive-full, bit 59 is transmit-full, and bits 55:48 hold the state (8'h01 idle, 8'h02 fetch, 8'h04 waiting for transmit data, 8'h08 shifting). All other bits read zero, as do the program register and unused addresses. Addresses 0, 1 and 2 read back their stored values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; read side effects take place at the clock edge |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for `reg_addr`, valid in the same cycle |
| sck | output | 1 | Serial clock, mode 0 |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | NCS | Active-low chip-selects |

## Verification
The bound checker checks several properties on every cycle. At most one chip-select is active, and chip-selects are released whenever the sequencer is idle. SCK is low whenever no shift is running, no high phase lasts longer than div+1 clocks, and MOSI holds steady through each high phase. The checker also confirms that taking transmit data empties the register, that a shift-in result always leaves receive-full set, that a soft reset returns the sequencer to idle, and that the overrun flag stays set until a status write.

Some behaviours only the bench's scenarios can show: the exact bit order on the wire, the receive word layout, the counted branch repeating the right number of times, the stalls on an empty transmit register (including the single dummy write in implicit mode), the flag values after each misuse, and the need for the arming write before a reset.

// File: rtl/spi_seq_pkg.sv
`timescale 1ns/1ps
package spi_seq_pkg;

  localparam int DATAW  = 64;
  localparam int DIVW   = 12;
  localparam int SLOTS  = 8;
  localparam int PCW    = $clog2(SLOTS);
  localparam int BITCW  = 7;

  localparam logic [3:0] A_LOOP = 4'd0;
  localparam logic [3:0] A_CLK  = 4'd1;
  localparam logic [3:0] A_TX   = 4'd2;
  localparam logic [3:0] A_RX   = 4'd3;
  localparam logic [3:0] A_PROG = 4'd4;
  localparam logic [3:0] A_STAT = 4'd5;

  localparam logic [3:0] OP_CTL = 4'h0;
  localparam logic [3:0] OP_SEL = 4'h1;
  localparam logic [3:0] OP_OUT = 4'h3;
  localparam logic [3:0] OP_IN  = 4'h4;
  localparam logic [3:0] OP_BR  = 4'hE;

  typedef enum logic [7:0] {
    ST_IDLE    = 8'h01,
    ST_FETCH   = 8'h02,
    ST_WAIT_TX = 8'h04,
    ST_SHIFT   = 8'h08
  } seq_state_e;

  // opcode at a slot: slot 0 is the most significant byte
  function automatic logic [7:0] prog_slot(input logic [DATAW-1:0] p, input logic [PCW-1:0] s);
    return p[DATAW-1-8*s -: 8];
  endfunction

  // byte count of a shift opcode, clamped to the register width
  function automatic logic [3:0] op_bytes(input logic [3:0] n);
    return (n > 4'd8) ? 4'd8 : n;
  endfunction

  function automatic logic [BITCW-1:0] bit_count(input logic [3:0] nbytes);
    return {nbytes, 3'b000};
  endfunction

  function automatic logic [DIVW:0] sck_half(input logic [DIVW-1:0] div);
    return {1'b0, div} + 1'b1;
  endfunction

  function automatic logic clk_arm(input logic [DATAW-1:0] w);
    return w[36] & w[38];
  endfunction

  function automatic logic clk_fire(input logic [DATAW-1:0] w);
    return w[37] & w[39];
  endfunction

  function automatic logic [DATAW-1:0] make_status(input logic rx_full, input logic rx_ovr,
                                                   input logic rx_und, input logic tx_full,
                                                   input logic tx_ovr, input logic [7:0] st);
    logic [DATAW-1:0] s;
    s = '0;
    s[63]    = rx_full;
    s[62]    = rx_ovr;
    s[61]    = rx_und;
    s[59]    = tx_full;
    s[58]    = tx_ovr;
    s[55:48] = st;
    return s;
  endfunction

endpackage

// File: rtl/spi_seq_sckgen.sv
`timescale 1ns/1ps
module spi_seq_sckgen
  import spi_seq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [DIVW-1:0] div,
  output logic            sck,
  output logic            rise,
  output logic            fall
);
  logic [DIVW-1:0] cnt;
  logic            wrap;

  assign wrap = run && (cnt == div);
  assign rise = wrap && !sck;
  assign fall = wrap && sck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      sck <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      sck <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      sck <= ~sck;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/spi_seq_shifter.sv
`timescale 1ns/1ps
module spi_seq_shifter
  import spi_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             start,
  input  logic             dir_out,
  input  logic [3:0]       nbytes,
  input  logic [DATAW-1:0] din,
  input  logic [DIVW-1:0]  div,
  input  logic             miso,
  output logic             sck,
  output logic             mosi,
  output logic             busy,
  output logic             done,
  output logic [DATAW-1:0] dout
);
  logic [DATAW-1:0] sh;
  logic [BITCW-1:0] bits_left;
  logic             dir_q;
  logic             rise;
  logic             fall;

  spi_seq_sckgen u_sckgen (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy),
    .div  (div),
    .sck  (sck),
    .rise (rise),
    .fall (fall)
  );

  assign done = busy && fall && (bits_left == BITCW'(1));
  assign mosi = busy && dir_q && sh[DATAW-1];
  assign dout = sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh        <= '0;
      bits_left <= '0;
      busy      <= 1'b0;
      dir_q     <= 1'b0;
    end else if (soft_rst) begin
      busy      <= 1'b0;
      bits_left <= '0;
    end else if (start && !busy) begin
      sh        <= dir_out ? din : '0;
      bits_left <= bit_count(nbytes);
      busy      <= 1'b1;
      dir_q     <= dir_out;
    end else if (busy) begin
      if (rise && !dir_q) sh <= {sh[DATAW-2:0], miso};
      if (fall) begin
        if (dir_q) sh <= {sh[DATAW-2:0], 1'b0};
        bits_left <= bits_left - 1'b1;
        if (bits_left == BITCW'(1)) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spi_seq_ctrl.sv
`timescale 1ns/1ps
module spi_seq_ctrl
  import spi_seq_pkg::*;
#(
  parameter int NCS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             prog_wr,
  input  logic [DATAW-1:0] prog_data,
  input  logic [7:0]       loop_init,
  input  logic             implicit_en,
  input  logic             tx_full,
  input  logic             shift_done,
  output seq_state_e       state,
  output logic [NCS-1:0]   cs_n,
  output logic             tx_take,
  output logic             shift_start,
  output logic             shift_dir_out,
  output logic [3:0]       shift_nbytes,
  output logic             rx_load,
  output logic             seq_idle
);
  logic [DATAW-1:0] prog, prog_n;
  logic [PCW-1:0]   pc, pc_n;
  logic [7:0]       loop_cnt, loop_n;
  logic             impl, impl_n;
  logic [NCS-1:0]   cs_n_n;
  logic [NCS-1:0]   cs_sel;
  seq_state_e       state_n;
  logic [7:0]       cur_op;
  logic             adv;
  logic             stop;

  assign cur_op        = prog_slot(prog, pc);
  assign shift_dir_out = (cur_op[7:4] == OP_OUT);
  assign shift_nbytes  = op_bytes(cur_op[3:0]);
  assign seq_idle      = (state == ST_IDLE);
  assign rx_load       = (state == ST_SHIFT) && shift_done && (cur_op[7:4] == OP_IN) && !soft_rst;

  for (genvar g = 0; g < NCS; g++) begin : g_csdec
    assign cs_sel[g] = (cur_op[3:0] != 4'(g + 1));
  end

  always_comb begin
    state_n     = state;
    prog_n      = prog;
    pc_n        = pc;
    loop_n      = loop_cnt;
    impl_n      = impl;
    cs_n_n      = cs_n;
    adv         = 1'b0;
    stop        = 1'b0;
    tx_take     = 1'b0;
    shift_start = 1'b0;
    case (state)
      ST_IDLE: begin
        if (prog_wr) begin
          prog_n  = prog_data;
          pc_n    = '0;
          loop_n  = loop_init;
          impl_n  = implicit_en;
          state_n = ST_FETCH;
        end
      end
      ST_FETCH: begin
        case (cur_op[7:4])
          OP_CTL: begin
            if (cur_op[3:0] == 4'h0) stop = 1'b1;
            else adv = 1'b1;
          end
          OP_SEL: begin
            cs_n_n = cs_sel;
            adv    = 1'b1;
          end
          OP_OUT: begin
            if (shift_nbytes == 4'd0) adv = 1'b1;
            else state_n = ST_WAIT_TX;
          end
          OP_IN: begin
            if (shift_nbytes == 4'd0) adv = 1'b1;
            else if (impl) state_n = ST_WAIT_TX;
            else begin
              state_n     = ST_SHIFT;
              shift_start = 1'b1;
            end
          end
          OP_BR: begin
            if (loop_cnt != 8'd0) begin
              loop_n = loop_cnt - 1'b1;
              pc_n   = cur_op[PCW-1:0];
            end else begin
              adv = 1'b1;
            end
          end
          default: adv = 1'b1;
        endcase
      end
      ST_WAIT_TX: begin
        if (tx_full) begin
          tx_take     = 1'b1;
          shift_start = 1'b1;
          state_n     = ST_SHIFT;
          if (cur_op[7:4] == OP_IN) impl_n = 1'b0;
        end
      end
      ST_SHIFT: begin
        if (shift_done) adv = 1'b1;
      end
      default: state_n = ST_IDLE;
    endcase
    if (adv) begin
      if (pc == PCW'(SLOTS - 1)) stop = 1'b1;
      else begin
        pc_n    = pc + 1'b1;
        state_n = ST_FETCH;
      end
    end
    if (stop) begin
      state_n = ST_IDLE;
      cs_n_n  = '1;
    end
    if (soft_rst) begin
      state_n     = ST_IDLE;
      cs_n_n      = '1;
      tx_take     = 1'b0;
      shift_start = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      prog     <= '0;
      pc       <= '0;
      loop_cnt <= '0;
      impl     <= 1'b0;
      cs_n     <= '1;
    end else begin
      state    <= state_n;
      prog     <= prog_n;
      pc       <= pc_n;
      loop_cnt <= loop_n;
      impl     <= impl_n;
      cs_n     <= cs_n_n;
    end
  end
endmodule

// File: rtl/spi_seq_master.sv
`timescale 1ns/1ps
module spi_seq_master
  import spi_seq_pkg::*;
#(
  parameter int NCS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [3:0]       reg_addr,
  input  logic [63:0]      reg_wdata,
  output logic [63:0]      reg_rdata,
  output logic             sck,
  output logic             mosi,
  input  logic             miso,
  output logic [NCS-1:0]   cs_n
);
  logic [DATAW-1:0] loop_cfg;
  logic [DATAW-1:0] clk_cfg;
  logic [DATAW-1:0] tx_data;
  logic [DATAW-1:0] rx_data;
  logic             tx_full, rx_full;
  logic             tx_ovr, rx_und, rx_ovr;
  logic             rst_armed;

  logic             wr_loop, wr_clk, wr_tx, wr_prog, stat_clr, rd_rx;
  logic             soft_rst;
  logic [DIVW-1:0]  clk_div;

  seq_state_e       state;
  logic             seq_idle;
  logic             tx_take, rx_load;
  logic             shift_start, shift_dir_out, shift_busy, shift_done;
  logic [3:0]       shift_nbytes;
  logic [DATAW-1:0] shift_dout;

  assign wr_loop  = reg_wr && (reg_addr == A_LOOP);
  assign wr_clk   = reg_wr && (reg_addr == A_CLK);
  assign wr_tx    = reg_wr && (reg_addr == A_TX);
  assign wr_prog  = reg_wr && (reg_addr == A_PROG);
  assign stat_clr = reg_wr && (reg_addr == A_STAT);
  assign rd_rx    = reg_rd && (reg_addr == A_RX);
  assign soft_rst = wr_clk && rst_armed && clk_fire(reg_wdata);
  assign clk_div  = clk_cfg[63:52];

  spi_seq_ctrl #(.NCS(NCS)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .soft_rst     (soft_rst),
    .prog_wr      (wr_prog),
    .prog_data    (reg_wdata),
    .loop_init    (loop_cfg[39:32]),
    .implicit_en  (loop_cfg[10]),
    .tx_full      (tx_full),
    .shift_done   (shift_done),
    .state        (state),
    .cs_n         (cs_n),
    .tx_take      (tx_take),
    .shift_start  (shift_start),
    .shift_dir_out(shift_dir_out),
    .shift_nbytes (shift_nbytes),
    .rx_load      (rx_load),
    .seq_idle     (seq_idle)
  );

  spi_seq_shifter u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .soft_rst(soft_rst),
    .start   (shift_start),
    .dir_out (shift_dir_out),
    .nbytes  (shift_nbytes),
    .din     (tx_data),
    .div     (clk_div),
    .miso    (miso),
    .sck     (sck),
    .mosi    (mosi),
    .busy    (shift_busy),
    .done    (shift_done),
    .dout    (shift_dout)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loop_cfg  <= '0;
      clk_cfg   <= '0;
      rst_armed <= 1'b0;
    end else begin
      if (wr_loop) loop_cfg <= reg_wdata;
      if (wr_clk) begin
        clk_cfg   <= reg_wdata;
        rst_armed <= clk_arm(reg_wdata);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_data <= '0;
      tx_full <= 1'b0;
      rx_data <= '0;
      rx_full <= 1'b0;
      tx_ovr  <= 1'b0;
      rx_und  <= 1'b0;
      rx_ovr  <= 1'b0;
    end else begin
      if (stat_clr) begin
        tx_ovr <= 1'b0;
        rx_und <= 1'b0;
        rx_ovr <= 1'b0;
      end
      if (tx_take) tx_full <= 1'b0;
      if (wr_tx) begin
        if (tx_full) tx_ovr <= 1'b1;
        else begin
          tx_data <= reg_wdata;
          tx_full <= 1'b1;
        end
      end
      if (rd_rx) begin
        if (rx_full) rx_full <= 1'b0;
        else rx_und <= 1'b1;
      end
      if (rx_load) begin
        rx_data <= shift_dout;
        rx_full <= 1'b1;
        if (rx_full) rx_ovr <= 1'b1;
      end
      if (soft_rst) begin
        tx_full <= 1'b0;
        rx_full <= 1'b0;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_LOOP:  reg_rdata = loop_cfg;
      A_CLK:   reg_rdata = clk_cfg;
      A_TX:    reg_rdata = tx_data;
      A_RX:    reg_rdata = rx_data;
      A_STAT:  reg_rdata = make_status(rx_full, rx_ovr, rx_und, tx_full, tx_ovr, state);
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_seq_master_chk.sv
`timescale 1ns/1ps
module spi_seq_master_chk
  import spi_seq_pkg::*;
#(
  parameter int NCS = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NCS-1:0]  cs_n,
  input logic            sck,
  input logic            mosi,
  input logic            seq_idle,
  input logic            shift_busy,
  input logic            tx_take,
  input logic            tx_full,
  input logic            rx_load,
  input logic            rx_full,
  input logic            tx_ovr,
  input logic            stat_clr,
  input logic            soft_rst,
  input logic [DIVW-1:0] clk_div
);
  logic [DIVW:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_cnt <= '0;
    else if (sck && hi_cnt < sck_half(clk_div)) hi_cnt <= hi_cnt + 1'b1;
    else if (!sck) hi_cnt <= '0;
  end

  assert_cs_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~cs_n));
  assert_idle_release_R2: assert property (@(posedge clk) disable iff (!rst_n) seq_idle |-> (cs_n == '1));
  assert_sck_rest_R8: assert property (@(posedge clk) disable iff (!rst_n) !shift_busy |-> !sck);
  assert_sck_high_len_R8: assert property (@(posedge clk) disable iff (!rst_n) sck |-> (hi_cnt < sck_half(clk_div)));
  assert_mosi_hold_R8: assert property (@(posedge clk) disable iff (!rst_n) (sck && $past(sck)) |-> $stable(mosi));
  assert_take_empties_R4: assert property (@(posedge clk) disable iff (!rst_n) tx_take |=> !tx_full);
  assert_take_needs_full_R4: assert property (@(posedge clk) disable iff (!rst_n) tx_take |-> tx_full);
  assert_rx_fill_R5: assert property (@(posedge clk) disable iff (!rst_n) rx_load |=> rx_full);
  assert_ovr_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n) (tx_ovr && !stat_clr) |=> tx_ovr);
  assert_soft_idle_R11: assert property (@(posedge clk) disable iff (!rst_n) soft_rst |=> (seq_idle && !tx_full && !rx_full));
endmodule

bind spi_seq_master spi_seq_master_chk #(.NCS(NCS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_n      (cs_n),
  .sck       (sck),
  .mosi      (mosi),
  .seq_idle  (seq_idle),
  .shift_busy(shift_busy),
  .tx_take   (tx_take),
  .tx_full   (tx_full),
  .rx_load   (rx_load),
  .rx_full   (rx_full),
  .tx_ovr    (tx_ovr),
  .stat_clr  (stat_clr),
  .soft_rst  (soft_rst),
  .clk_div   (clk_div)
);

// File: tb/spi_seq_master_bench.sv
`timescale 1ns/1ps
module spi_seq_master_bench;
  localparam int NCS = 4;
  localparam logic [63:0] IDLE_ST = 64'h0001_0000_0000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [3:0]  reg_addr = 4'd0;
  logic [63:0] reg_wdata = 64'd0;
  logic [63:0] reg_rdata;
  logic        sck, mosi;
  logic        miso = 1'b0;
  logic [NCS-1:0] cs_n;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;
  int rise_cnt = 0;
  int hi_len = 0;
  int cur_div = 0;
  logic sck_q = 1'b0;
  logic mon_mosi[$];
  logic [NCS-1:0] mon_cs[$];

  always #2.5 clk = ~clk;

  spi_seq_master #(.NCS(NCS)) u_spi_seq_master (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // slave data pattern, indexed by the global count of rising SCK edges
  function automatic logic pat(input int i);
    return ((i * 13 + (i >> 2)) % 3) != 0;
  endfunction

  function automatic logic [63:0] exp_in(input int first, input int nbits);
    logic [63:0] v = 64'd0;
    for (int i = 0; i < nbits; i++) v = {v[62:0], pat(first + i)};
    return v;
  endfunction

  // per-clock reference: SCK high phase length, wire log, slave drive
  always @(negedge clk) begin
    if (rst_n) begin
      if (sck && !sck_q) begin
        mon_mosi.push_back(mosi);
        mon_cs.push_back(cs_n);
        rise_cnt++;
      end
      if (sck) hi_len++;
      else if (hi_len > 0) begin
        chk(hi_len == cur_div + 1, "R8 sck high length", 64'(hi_len), 64'(cur_div + 1));
        hi_len = 0;
      end
    end
    sck_q = sck;
    miso = pat(rise_cnt);
  end

  task automatic wr(input logic [3:0] a, input logic [63:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    if (a == 4'd1) cur_div = int'(d[63:52]);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [63:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wait_status(input int bitpos, input logic val, input logic [7:0] st, input bit use_st);
    logic [63:0] s;
    for (int k = 0; k < 4000; k++) begin
      rd(4'd5, s);
      if (use_st ? (s[55:48] == st) : (s[bitpos] == val)) return;
    end
    chk(1'b0, "poll timeout", s, 64'd0);
  endtask

  task automatic chk_wire(input int first, input int nbits, input logic [63:0] expv,
                          input logic [NCS-1:0] cs_exp, input string req);
    logic [63:0] v = 64'd0;
    bit cs_ok = 1;
    if (mon_mosi.size() < first + nbits) begin
      chk(1'b0, req, 64'(mon_mosi.size()), 64'(first + nbits));
      return;
    end
    for (int i = 0; i < nbits; i++) begin
      v = {v[62:0], mon_mosi[first + i]};
      if (mon_cs[first + i] != cs_exp) cs_ok = 0;
    end
    chk(v == expv, req, v, expv);
    chk(cs_ok, "R3 chip-select during shift", 64'(mon_cs[first]), 64'(cs_exp));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] d, v1, v2;
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(4'd5, d);
    chk(d == IDLE_ST, "R1 status after reset", d, IDLE_ST);
    chk(cs_n == 4'hF && !sck && !mosi, "R1 pins after reset", {cs_n, sck, mosi}, {4'hF, 2'b00});

    // R4 / R2 plain shift-out of two bytes, stop opcode
    wr(4'd1, 64'd1 << 52);
    wr(4'd0, 64'd0);
    base = rise_cnt;
    wr(4'd2, 64'hA5C3_1234_5678_9ABC);
    wr(4'd4, 64'h1132_1000_0000_0000);
    wait_status(0, 1'b0, 8'h01, 1);
    chk_wire(base, 16, 64'hA5C3, 4'b1110, "R4 shift-out bytes");
    chk(rise_cnt - base == 16, "R2 stop ends program", 64'(rise_cnt - base), 64'd16);
    rd(4'd5, d);
    chk(d == IDLE_ST, "R12 status idle, transmit empty", d, IDLE_ST);
    chk(cs_n == 4'hF, "R2 release on idle", 64'(cs_n), 64'hF);

    // R5 out then in on chip-select 2
    base = rise_cnt;
    wr(4'd2, 64'h3C00_0000_0000_0000);
    wr(4'd4, 64'h1231_4210_0000_0000);
    wait_status(0, 1'b0, 8'h01, 1);
    chk_wire(base, 24, {40'd0, 8'h3C, 16'h0000}, 4'b1101, "R5 mosi low while receiving");
    rd(4'd5, d);
    chk(d == 64'h8001_0000_0000_0000, "R5 receive-full set", d, 64'h8001_0000_0000_0000);
    rd(4'd3, d);
    chk(d == exp_in(base + 8, 16), "R5 receive word layout", d, exp_in(base + 8, 16));
    rd(4'd5, d);
    chk(d == IDLE_ST, "R5 read clears receive-full", d, IDLE_ST);

    // R6 counted branch, stall on empty transmit register
    wr(4'd0, 64'd2 << 32);
    base = rise_cnt;
    wr(4'd2, 64'h8100_0000_0000_0000);
    wr(4'd4, 64'h1131_E110_0000_0000);
    wait_status(59, 1'b0, 8'h00, 0);
    repeat (60) @(negedge clk);
    rd(4'd5, d);
    chk(rise_cnt - base == 8, "R4 stall on empty transmit", 64'(rise_cnt - base), 64'd8);
    chk(d[55:48] == 8'h04, "R12 waiting state", 64'(d[55:48]), 64'h04);
    wr(4'd2, 64'h7E00_0000_0000_0000);
    wait_status(59, 1'b0, 8'h00, 0);
    wr(4'd2, 64'h5A00_0000_0000_0000);
    wait_status(0, 1'b0, 8'h01, 1);
    chk_wire(base, 24, 64'h817E5A, 4'b1110, "R6 loop runs three times");
    chk(rise_cnt - base == 24, "R6 loop count", 64'(rise_cnt - base), 64'd24);

    // R7 implicit mode: one dummy write, then two receive stages
    wr(4'd1, 64'd3 << 52);
    wr(4'd0, (64'd1 << 32) | (64'd1 << 10));
    base = rise_cnt;
    wr(4'd2, 64'hC600_0000_0000_0000);
    wr(4'd4, 64'h1131_42E2_1000_0000);
    wait_status(59, 1'b0, 8'h00, 0);
    repeat (120) @(negedge clk);
    chk(rise_cnt - base == 8, "R7 shift-in waits for dummy write", 64'(rise_cnt - base), 64'd8);
    wr(4'd2, 64'd0);
    wait_status(63, 1'b1, 8'h00, 0);
    rd(4'd3, v1);
    wait_status(63, 1'b1, 8'h00, 0);
    rd(4'd3, v2);
    wait_status(0, 1'b0, 8'h01, 1);
    chk(v1 == exp_in(base + 8, 16), "R7 first receive", v1, exp_in(base + 8, 16));
    chk(v2 == exp_in(base + 24, 16), "R7 second receive without wait", v2, exp_in(base + 24, 16));
    rd(4'd5, d);
    chk(d == IDLE_ST, "R7 no flags after implicit run", d, IDLE_ST);

    // R9 receive overrun, underrun; R10 status clear
    wr(4'd1, 64'd1 << 52);
    wr(4'd0, 64'd0);
    base = rise_cnt;
    wr(4'd4, 64'h1141_4110_0000_0000);
    wait_status(0, 1'b0, 8'h01, 1);
    rd(4'd5, d);
    chk(d == 64'hC001_0000_0000_0000, "R9 receive overrun", d, 64'hC001_0000_0000_0000);
    rd(4'd3, d);
    chk(d == exp_in(base + 8, 8), "R9 overrun replaces data", d, exp_in(base + 8, 8));
    rd(4'd3, d);
    rd(4'd5, d);
    chk(d == 64'h6001_0000_0000_0000, "R9 receive underrun", d, 64'h6001_0000_0000_0000);
    wr(4'd5, 64'd0);
    rd(4'd5, d);
    chk(d == IDLE_ST, "R10 status write clears flags", d, IDLE_ST);

    // R9 transmit overrun keeps first data
    wr(4'd2, 64'h1111_2222_3333_4444);
    wr(4'd2, 64'h9999_8888_7777_6666);
    rd(4'd5, d);
    chk(d == 64'h0C01_0000_0000_0000, "R9 transmit overrun", d, 64'h0C01_0000_0000_0000);
    rd(4'd2, d);
    chk(d == 64'h1111_2222_3333_4444, "R9 transmit data kept", d, 64'h1111_2222_3333_4444);

    // R11 soft reset clears transmit-full
    wr(4'd1, (64'd1 << 36) | (64'd1 << 38));
    wr(4'd1, (64'd1 << 37) | (64'd1 << 39));
    rd(4'd5, d);
    chk(d == 64'h0401_0000_0000_0000, "R11 reset clears transmit-full", d, 64'h0401_0000_0000_0000);
    wr(4'd5, 64'd0);

    // R11 reset of a stalled program, fire without arm ignored
    wr(4'd1, 64'd1 << 52);
    wr(4'd4, 64'h1131_1000_0000_0000);
    repeat (20) @(negedge clk);
    rd(4'd5, d);
    chk(d == 64'h0004_0000_0000_0000 && cs_n == 4'b1110, "R11 stalled before reset", d, 64'h0004_0000_0000_0000);
    wr(4'd1, (64'd1 << 52) | (64'd1 << 37) | (64'd1 << 39));
    rd(4'd5, d);
    chk(d == 64'h0004_0000_0000_0000, "R11 second write alone ignored", d, 64'h0004_0000_0000_0000);
    wr(4'd1, (64'd1 << 36) | (64'd1 << 38));
    wr(4'd1, (64'd1 << 37) | (64'd1 << 39));
    rd(4'd5, d);
    chk(d == IDLE_ST && cs_n == 4'hF, "R11 reset to idle", d, IDLE_ST);
    wr(4'd1, 64'd1 << 52);

    // R2 / R4 / R5 run past slot 7 with zero-length shifts
    base = rise_cnt;
    wr(4'd4, 64'h1130_4010_1230_1012);
    repeat (30) @(negedge clk);
    rd(4'd5, d);
    chk(d == IDLE_ST, "R2 idle after slot 7", d, IDLE_ST);
    chk(cs_n == 4'hF && rise_cnt == base, "R4 zero-length shifts are no-ops", 64'(rise_cnt - base), 64'd0);
    rd(4'd0, d);
    chk(d == 64'd0, "R12 counter config readback", d, 64'd0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule